// File: doc/BRIEF.md
# Dual-Consumer Instruction Fetch Matcher

This block hands out instruction words to two consumers that fetch the same program at different paces. The primary consumer is a pipelined core. Each fetch it makes draws a fresh word from an instruction source, and that word is returned in the same cycle. This holds even when the PC has been fetched before. Each word delivered this way is remembered, together with its PC, in a pending queue of parameterised depth. While the queue is full, the primary consumer is held off.

The second consumer is a reference model that runs behind the core. When it presents a PC, the pending queue is searched from the oldest entry. The first entry with that PC supplies the reply one cycle later. That entry is removed, and so is every entry older than it. Those older words are ones the core prefetched but never executed, or ones passed over by a jump or trap.

A reference fetch that finds no pending entry gets a miss reply. It also raises a sticky error flag, which keeps the PC of the first offending fetch until reset. If both consumers fetch in the same cycle, the primary word is queued first, so the reference lookup can already see it.

Top module: `dual_fetch_matcher`

## Requirements
- R1: After reset the queue is empty, so `pri_ready` is 1, `rsp_valid` is 0 and `err_flag` is 0.
- R2: In a cycle with `pri_req` and `pri_ready` both high, `src_take` is 1 and `pri_insn` equals `src_insn` in that cycle. A repeated PC still draws a new source word.
- R3: `pri_ready` is 0 when DEPTH entries are pending at the start of the cycle, even if a reference hit removes entries in that same cycle. `src_take` is never 1 unless `pri_req` and `pri_ready` are both 1.
- R4: A reference fetch that matches a pending PC produces, one cycle later, `rsp_valid`=1, `rsp_hit`=1 and `rsp_insn` equal to the word that was delivered to the primary consumer for that entry.
- R5: When several pending entries share the PC, the oldest of them answers.
- R6: On a hit, the matched entry and every entry older than it are removed. A later reference fetch of a removed PC misses.
- R7: A reference fetch with no matching entry gives `rsp_valid`=1, `rsp_hit`=0 and `rsp_insn`=0 one cycle later, and leaves the queue unchanged. `err_flag` becomes 1 at that same edge and stays 1 until reset.
- R8: `err_pc` holds the PC of the first missing reference fetch since reset. Later misses do not change it.
- R9: When a primary fetch and a reference fetch arrive in the same cycle, the primary word is queued before the lookup. A reference fetch of the same PC therefore hits and receives that word.
- R10: `rsp_valid` is 1 exactly in the cycle after a cycle with `ref_req` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_req | input | 1 | Primary consumer fetch request |
| pri_pc | input | PC_W | PC of the primary fetch |
| pri_ready | output | 1 | Primary fetch can be accepted (queue not full) |
| pri_insn | output | INSN_W | Word returned to the primary consumer |
| src_insn | input | INSN_W | Next word offered by the instruction source |
| src_take | output | 1 | Source word consumed this cycle |
| ref_req | input | 1 | Reference consumer fetch request |
| ref_pc | input | PC_W | PC of the reference fetch |
| rsp_valid | output | 1 | Reference reply present (one cycle after request) |
| rsp_hit | output | 1 | Reference reply found a pending entry |
| rsp_insn | output | INSN_W | Reference reply word (0 on a miss) |
| err_flag | output | 1 | Sticky mismatch flag |
| err_pc | output | PC_W | PC of the first mismatching reference fetch |

## Verification
Some behaviours are checked by the assertions on every cycle. These are the one-cycle timing of the reference reply, the stickiness of the error flag and the freezing of `err_pc`. They also cover the rule that a miss reply always comes with the flag set, the gating of `src_take`, and the bound on occupancy, which never grows by more than one entry per cycle.

Other behaviours depend on which words were queued, and only the bench scenarios can show them. These are oldest-first selection among duplicate PCs, removal of skipped older entries, the push-before-lookup ordering, the stall at exactly full, and the queue being left unchanged after a miss. The bench shows them by comparing every reply word against a behavioural queue model.

// File: rtl/fm_pkg.sv
package fm_pkg;

  // Position of the entry that is `off` places younger than `base` in a ring of `depth` slots.
  // Requires base < depth and off <= depth.
  function automatic int unsigned ring_idx(int unsigned base, int unsigned off,
                                           int unsigned depth);
    int unsigned s;
    s = base + off;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/fm_ring.sv
module fm_ring #(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int INSN_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PC_W-1:0]   push_pc,
  input  logic [INSN_W-1:0] push_insn,
  input  logic [CNT_W-1:0]  drop_n,
  output logic [CNT_W-1:0]  occ,
  output logic              age_vld  [DEPTH],
  output logic [PC_W-1:0]   age_pc   [DEPTH],
  output logic [INSN_W-1:0] age_insn [DEPTH]
);
  import fm_pkg::*;

  logic [PTR_W-1:0]  head_q, head_d;
  logic [CNT_W-1:0]  occ_q, occ_d;
  logic [PTR_W-1:0]  tail;
  logic [PC_W-1:0]   pc_q   [DEPTH];
  logic [INSN_W-1:0] insn_q [DEPTH];

  always_comb begin
    tail   = PTR_W'(ring_idx(int'(head_q), int'(occ_q), DEPTH));
    head_d = PTR_W'(ring_idx(int'(head_q), int'(drop_n), DEPTH));
    occ_d  = occ_q + CNT_W'(push) - drop_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= head_d;
      occ_q  <= occ_d;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic wr_en;
    assign wr_en = push && (tail == PTR_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q[s]   <= '0;
        insn_q[s] <= '0;
      end else if (wr_en) begin
        pc_q[s]   <= push_pc;
        insn_q[s] <= push_insn;
      end
    end
  end

  for (genvar a = 0; a < DEPTH; a++) begin : g_age
    logic [PTR_W-1:0] slot;
    assign slot        = PTR_W'(ring_idx(int'(head_q), a, DEPTH));
    assign age_vld[a]  = (int'(occ_q) > a);
    assign age_pc[a]   = pc_q[slot];
    assign age_insn[a] = insn_q[slot];
  end

  assign occ = occ_q;

endmodule

// File: rtl/fm_search.sv
module fm_search #(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int INSN_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              age_vld  [DEPTH],
  input  logic [PC_W-1:0]   age_pc   [DEPTH],
  input  logic [INSN_W-1:0] age_insn [DEPTH],
  input  logic [CNT_W-1:0]  occ,
  input  logic              push,
  input  logic [PC_W-1:0]   push_pc,
  input  logic [INSN_W-1:0] push_insn,
  input  logic [PC_W-1:0]   look_pc,
  output logic              hit,
  output logic [INSN_W-1:0] hit_insn,
  output logic [CNT_W-1:0]  drop_n
);
  logic              cand_vld  [DEPTH];
  logic [PC_W-1:0]   cand_pc   [DEPTH];
  logic [INSN_W-1:0] cand_insn [DEPTH];
  logic [DEPTH-1:0]  match;

  // The word being pushed this cycle occupies the first free age position.
  for (genvar a = 0; a < DEPTH; a++) begin : g_cand
    logic incoming;
    assign incoming     = push && (int'(occ) == a);
    assign cand_vld[a]  = age_vld[a] || incoming;
    assign cand_pc[a]   = age_vld[a] ? age_pc[a]   : push_pc;
    assign cand_insn[a] = age_vld[a] ? age_insn[a] : push_insn;
    assign match[a]     = cand_vld[a] && (cand_pc[a] == look_pc);
  end

  // Oldest match wins: scan from youngest down so the lowest index is kept.
  always_comb begin
    hit      = 1'b0;
    hit_insn = '0;
    drop_n   = '0;
    for (int a = DEPTH - 1; a >= 0; a--) begin
      if (match[a]) begin
        hit      = 1'b1;
        hit_insn = cand_insn[a];
        drop_n   = CNT_W'(a + 1);
      end
    end
  end

endmodule

// File: rtl/fm_errlog.sv
module fm_errlog #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            miss,
  input  logic [PC_W-1:0] miss_pc,
  output logic            err_flag,
  output logic [PC_W-1:0] err_pc
);
  logic            flag_q, flag_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            capture;

  always_comb begin
    capture = miss && !flag_q;
    flag_d  = flag_q || miss;
    pc_d    = capture ? miss_pc : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pc_q   <= '0;
    end else begin
      flag_q <= flag_d;
      pc_q   <= pc_d;
    end
  end

  assign err_flag = flag_q;
  assign err_pc   = pc_q;

endmodule

// File: rtl/dual_fetch_matcher.sv
module dual_fetch_matcher #(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pri_req,
  input  logic [PC_W-1:0]   pri_pc,
  output logic              pri_ready,
  output logic [INSN_W-1:0] pri_insn,
  input  logic [INSN_W-1:0] src_insn,
  output logic              src_take,
  input  logic              ref_req,
  input  logic [PC_W-1:0]   ref_pc,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [INSN_W-1:0] rsp_insn,
  output logic              err_flag,
  output logic [PC_W-1:0]   err_pc
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  occ;
  logic              age_vld  [DEPTH];
  logic [PC_W-1:0]   age_pc   [DEPTH];
  logic [INSN_W-1:0] age_insn [DEPTH];
  logic              fire;
  logic              hit;
  logic [INSN_W-1:0] hit_insn;
  logic [CNT_W-1:0]  drop_cand, drop_n;
  logic              miss;

  logic              vld_q, vld_d;
  logic              hit_q, hit_d;
  logic [INSN_W-1:0] insn_q, insn_d;

  assign pri_ready = (occ != CNT_W'(DEPTH));
  assign fire      = pri_req && pri_ready;
  assign src_take  = fire;
  assign pri_insn  = src_insn;

  fm_ring #(.DEPTH(DEPTH), .PC_W(PC_W), .INSN_W(INSN_W)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (fire),
    .push_pc  (pri_pc),
    .push_insn(src_insn),
    .drop_n   (drop_n),
    .occ      (occ),
    .age_vld  (age_vld),
    .age_pc   (age_pc),
    .age_insn (age_insn)
  );

  fm_search #(.DEPTH(DEPTH), .PC_W(PC_W), .INSN_W(INSN_W)) u_search (
    .age_vld  (age_vld),
    .age_pc   (age_pc),
    .age_insn (age_insn),
    .occ      (occ),
    .push     (fire),
    .push_pc  (pri_pc),
    .push_insn(src_insn),
    .look_pc  (ref_pc),
    .hit      (hit),
    .hit_insn (hit_insn),
    .drop_n   (drop_cand)
  );

  assign drop_n = (ref_req && hit) ? drop_cand : '0;
  assign miss   = ref_req && !hit;

  fm_errlog #(.PC_W(PC_W)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .miss    (miss),
    .miss_pc (ref_pc),
    .err_flag(err_flag),
    .err_pc  (err_pc)
  );

  always_comb begin
    vld_d  = ref_req;
    hit_d  = ref_req && hit;
    insn_d = insn_q;
    if (ref_req) insn_d = hit ? hit_insn : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hit_q  <= 1'b0;
      insn_q <= '0;
    end else begin
      vld_q  <= vld_d;
      hit_q  <= hit_d;
      insn_q <= insn_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_hit   = hit_q;
  assign rsp_insn  = insn_q;

endmodule

// File: rtl/fm_chk.sv
module fm_chk #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pri_req,
  input logic             pri_ready,
  input logic             src_take,
  input logic             ref_req,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             err_flag,
  input logic [PC_W-1:0]  err_pc,
  input logic [CNT_W-1:0] occ
);
  // R10
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |=> rsp_valid);
  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_req |=> !rsp_valid);
  // R4
  hit_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  // R7
  miss_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> err_flag);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  // R8
  err_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> $stable(err_pc));
  // R3
  take_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_take |-> (pri_req && pri_ready));
  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);
  // R6
  occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= int'($past(occ)) + 1);
endmodule

bind dual_fetch_matcher fm_chk #(.DEPTH(DEPTH), .PC_W(PC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pri_req  (pri_req),
  .pri_ready(pri_ready),
  .src_take (src_take),
  .ref_req  (ref_req),
  .rsp_valid(rsp_valid),
  .rsp_hit  (rsp_hit),
  .err_flag (err_flag),
  .err_pc   (err_pc),
  .occ      (occ)
);

// File: tb/dual_fetch_matcher_tb.sv
module dual_fetch_matcher_tb;
  localparam int DEPTH  = 4;
  localparam int PC_W   = 32;
  localparam int INSN_W = 32;

  logic              clk;
  logic              rst_n;
  logic              pri_req;
  logic [PC_W-1:0]   pri_pc;
  logic              pri_ready;
  logic [INSN_W-1:0] pri_insn;
  logic [INSN_W-1:0] src_insn;
  logic              src_take;
  logic              ref_req;
  logic [PC_W-1:0]   ref_pc;
  logic              rsp_valid;
  logic              rsp_hit;
  logic [INSN_W-1:0] rsp_insn;
  logic              err_flag;
  logic [PC_W-1:0]   err_pc;

  dual_fetch_matcher #(.DEPTH(DEPTH), .PC_W(PC_W), .INSN_W(INSN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pri_req(pri_req), .pri_pc(pri_pc),
    .pri_ready(pri_ready), .pri_insn(pri_insn), .src_insn(src_insn),
    .src_take(src_take), .ref_req(ref_req), .ref_pc(ref_pc),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_insn(rsp_insn),
    .err_flag(err_flag), .err_pc(err_pc)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [PC_W-1:0]   m_pc[$];
  logic [INSN_W-1:0] m_insn[$];
  bit                m_err;
  logic [PC_W-1:0]   m_err_pc;
  int unsigned       word_seq = 1;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pri_req = 1'b0; ref_req = 1'b0;
    pri_pc = '0; ref_pc = '0; src_insn = '0;
    m_pc.delete(); m_insn.delete(); m_err = 1'b0; m_err_pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(pri_ready == 1'b1, "R1", "pri_ready", pri_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
    chk(err_flag == 1'b0,  "R1", "err_flag",  err_flag, 0);
  endtask

  // One cycle: drive at the falling edge, check combinational outputs,
  // advance the model, then check the registered outputs after the rising edge.
  task automatic step(bit preq, logic [PC_W-1:0] ppc, bit rreq,
                      logic [PC_W-1:0] rpc, string tag);
    bit e_ready, e_fire, e_hit;
    logic [INSN_W-1:0] e_insn;
    logic [INSN_W-1:0] w;
    int k;
    @(negedge clk);
    w = word_seq * 32'h9E37_79B1 + 32'h1234;
    word_seq++;
    pri_req = preq; pri_pc = ppc; ref_req = rreq; ref_pc = rpc; src_insn = w;
    #1;
    e_ready = (m_pc.size() < DEPTH);
    e_fire  = preq && e_ready;
    chk(pri_ready == e_ready, "R3", "pri_ready", pri_ready, e_ready);
    chk(src_take == e_fire,   "R3", "src_take",  src_take, e_fire);
    if (e_fire) begin
      chk(pri_insn == w, "R2", "pri_insn", pri_insn, w);
      m_pc.push_back(ppc); m_insn.push_back(w);
    end
    e_hit = 1'b0; e_insn = '0;
    if (rreq) begin
      k = -1;
      foreach (m_pc[i]) if (k < 0 && m_pc[i] == rpc) k = i;
      if (k >= 0) begin
        e_hit = 1'b1; e_insn = m_insn[k];
        for (int j = 0; j <= k; j++) begin
          void'(m_pc.pop_front()); void'(m_insn.pop_front());
        end
      end else if (!m_err) begin
        m_err = 1'b1; m_err_pc = rpc;
      end
    end
    @(posedge clk);
    #1;
    pri_req = 1'b0; ref_req = 1'b0;
    chk(rsp_valid == rreq, "R10", "rsp_valid", rsp_valid, rreq);
    if (rreq) begin
      chk(rsp_hit == e_hit,   tag, "rsp_hit",  rsp_hit, e_hit);
      chk(rsp_insn == e_insn, tag, "rsp_insn", rsp_insn, e_insn);
    end
    chk(err_flag == m_err, "R7", "err_flag", err_flag, m_err);
    if (m_err) chk(err_pc == m_err_pc, "R8", "err_pc", err_pc, m_err_pc);
  endtask

  initial begin
    do_reset();
    // R2: repeated PC draws new words
    step(1, 32'h100, 0, 0, "R2");
    step(1, 32'h104, 0, 0, "R2");
    step(1, 32'h100, 0, 0, "R2");
    // R5: duplicate PC, oldest answers
    step(0, 0, 1, 32'h100, "R5");
    // R6: second 0x100 skips 0x104
    step(0, 0, 1, 32'h100, "R6");
    step(0, 0, 0, 0, "R10");
    // R6: skipped PC now misses (also R7)
    step(0, 0, 1, 32'h104, "R6");
    do_reset();
    // R3: fill to DEPTH then stall
    for (int i = 0; i < DEPTH; i++) step(1, 32'h200 + 4 * i, 0, 0, "R3");
    step(1, 32'h300, 0, 0, "R3");
    // R3: full with same-cycle reference hit still stalls
    step(1, 32'h300, 1, 32'h204, "R3");
    // R4: serve remaining entries
    step(0, 0, 1, 32'h208, "R4");
    step(0, 0, 1, 32'h20C, "R4");
    // R9: push and lookup of same PC in one cycle
    step(1, 32'h400, 1, 32'h400, "R9");
    step(1, 32'h404, 0, 0, "R9");
    step(1, 32'h408, 1, 32'h408, "R9");
    // R7: miss leaves queue intact; R8: first PC kept
    step(1, 32'h500, 0, 0, "R7");
    step(0, 0, 1, 32'h5FC, "R7");
    step(0, 0, 1, 32'h6FC, "R8");
    step(0, 0, 1, 32'h500, "R7");
    do_reset();
    // R4: mixed traffic over a small PC set
    for (int i = 0; i < 400; i++) begin
      bit pr, rr;
      logic [PC_W-1:0] pp, rp;
      pr = ($urandom_range(0, 99) < 60);
      rr = ($urandom_range(0, 99) < 45);
      pp = 32'h800 + 4 * $urandom_range(0, 5);
      rp = (m_pc.size() > 0 && $urandom_range(0, 9) < 9)
           ? m_pc[$urandom_range(0, m_pc.size() - 1)]
           : 32'h800 + 4 * $urandom_range(0, 5);
      step(pr, pp, rr, rp, "R4");
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule